// File: doc/BRIEF.md
# Re-framing Video Timing Generator

This block rebuilds the three raster timing signals of a video stream (horizontal blank, vertical blank and active video) from a set of working timing parameters. It holds a column counter and a row counter that run freely over a raster of `total_cols` by `total_rows` clocks. Whenever the incoming vertical blank goes from blanked to non-blanked, it snaps both counters back to the origin. The output frame therefore stays locked to the input frame, while the blanked regions can be moved and the active window cropped or shifted by programming indices. The frame size and the pixel rate do not change.

Row coordinates are counted from the first line of the vertical non-blank period. The non-blank rows come first and the `blank_rows` blank lines end the raster. Each output is registered. Per-signal polarity bits choose between valid signalling (high means visible) and blank signalling (high means blanked) for the two blanking outputs. A clock enable freezes the whole block. A synchronous clear empties it.

Top module: `vtg_timing_gen`

## Requirements
- R1: While `sclr` is high at a clock edge, all three outputs are 0 after that edge, and the column and row counters restart from 0.
- R2: On each clock edge with `ce` high, the column counter advances by one and wraps to 0 after `total_cols-1`. The row counter advances when the column wraps and goes to 0 after `total_rows-1`. With no input frame edges, the horizontal pattern repeats every `total_cols` enabled clocks.
- R3: The horizontal valid condition holds for column `c` when `blank_left <= c < blank_right`.
- R4: The vertical valid condition holds for row `r` when `r < total_rows - blank_rows`, so the last `blank_rows` lines of the raster are vertically blanked.
- R5: `active_out` is 1 only for column `c` with `active_left <= c < active_right` and row `r` with `active_top <= r < active_bottom`. Under the parameter constraints (`blank_left <= active_left`, `active_right <= blank_right`, `active_left > 3`, `active_right < total_cols-5`, active width and height above 31, `blank_rows > 2`, horizontal blank clocks above 2), it is only ever 1 while both blanking outputs show valid.
- R6: An input frame edge is `vblank_in` (1 = blanked) sampled 1 at one enabled edge and 0 at the next enabled edge. It reloads both counters to 0 at that second edge. The outputs for position (0,0) appear one enabled clock later.
- R7: `polarity[0]` sets the sense of `hblank_out` and `polarity[1]` sets the sense of `vblank_out`. A bit value of 1 drives the output high while valid; a value of 0 drives it high while blanked. `active_out` is always active high.
- R8: While `ce` is low, outputs, counters and the frame-edge history all hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| ce | input | 1 | Clock enable; low freezes the block |
| sclr | input | 1 | Synchronous clear, active high |
| vblank_in | input | 1 | Input vertical blank, 1 = blanked |
| polarity | input | 2 | Output sense: bit 1 vertical, bit 0 horizontal; 1 = valid-high |
| total_cols | input | COL_W | Clocks per line |
| total_rows | input | ROW_W | Lines per frame |
| blank_rows | input | ROW_W | Vertically blanked lines at the end of the raster |
| blank_left | input | COL_W | First horizontally visible column |
| blank_right | input | COL_W | First horizontally blanked column after the visible span |
| active_left | input | COL_W | First active column |
| active_right | input | COL_W | First non-active column after the active span |
| active_top | input | ROW_W | First active row |
| active_bottom | input | ROW_W | First non-active row below the active span |
| hblank_out | output | 1 | Horizontal blank output, sense per `polarity[0]` |
| vblank_out | output | 1 | Vertical blank output, sense per `polarity[1]` |
| active_out | output | 1 | Active video output, active high |

## Verification
A wrong column count shows up within one line: the `hblank_out` edges and the `active_out` pulse move against the reference model's positions. A wrong row count or a missed frame reload only appears at a window boundary. That is the first `vblank_out` transition, or the first row of the active window after the input edge. The bench therefore runs input frames whose length differs from the programmed raster, so each reload lands in the middle of a line. It also gates `ce` in a repeating pattern, so a counter that moves while disabled shifts every later edge by one clock, and the per-clock comparison catches it on the next boundary.

// File: rtl/vtg_pkg.sv
package vtg_pkg;

    localparam int POL_H = 0;
    localparam int POL_V = 1;

    typedef struct packed {
        logic h_vis;
        logic v_vis;
        logic act;
    } vtg_flags_t;

    typedef struct packed {
        logic hb;
        logic vb;
        logic av;
    } vtg_out_t;

endpackage

// File: rtl/vtg_counter.sv
module vtg_counter #(
    parameter int COL_W = 12,
    parameter int ROW_W = 12
) (
    input  logic             clk,
    input  logic             ce,
    input  logic             sclr,
    input  logic             vblank_in,
    input  logic [COL_W-1:0] total_cols,
    input  logic [ROW_W-1:0] total_rows,
    output logic [COL_W-1:0] col,
    output logic [ROW_W-1:0] row
);

    typedef struct packed {
        logic [COL_W-1:0] col;
        logic [ROW_W-1:0] row;
        logic             vb_prev;
    } cnt_state_t;

    cnt_state_t st_d, st_q;
    logic       frame_edge;
    logic       col_last;
    logic       row_last;

    always_comb begin
        st_d       = st_q;
        frame_edge = st_q.vb_prev & ~vblank_in;
        col_last   = (st_q.col >= total_cols - COL_W'(1));
        row_last   = (st_q.row >= total_rows - ROW_W'(1));
        if (ce) begin
            st_d.vb_prev = vblank_in;
            if (frame_edge) begin
                st_d.col = '0;
                st_d.row = '0;
            end else if (col_last) begin
                st_d.col = '0;
                st_d.row = row_last ? '0 : st_q.row + ROW_W'(1);
            end else begin
                st_d.col = st_q.col + COL_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (sclr) st_q <= '0;
        else      st_q <= st_d;
    end

    assign col = st_q.col;
    assign row = st_q.row;

endmodule

// File: rtl/vtg_window.sv
module vtg_window
    import vtg_pkg::*;
#(
    parameter int COL_W = 12,
    parameter int ROW_W = 12
) (
    input  logic [COL_W-1:0] col,
    input  logic [ROW_W-1:0] row,
    input  logic [ROW_W-1:0] total_rows,
    input  logic [ROW_W-1:0] blank_rows,
    input  logic [COL_W-1:0] blank_left,
    input  logic [COL_W-1:0] blank_right,
    input  logic [COL_W-1:0] active_left,
    input  logic [COL_W-1:0] active_right,
    input  logic [ROW_W-1:0] active_top,
    input  logic [ROW_W-1:0] active_bottom,
    output vtg_flags_t       flags
);

    localparam int RW1 = ROW_W + 1;

    logic [RW1-1:0] nb_rows;
    logic           in_cols;
    logic           in_rows;

    always_comb begin
        nb_rows     = {1'b0, total_rows} - {1'b0, blank_rows};
        in_cols     = (col >= active_left) && (col < active_right);
        in_rows     = (row >= active_top) && (row < active_bottom);
        flags.h_vis = (col >= blank_left) && (col < blank_right);
        flags.v_vis = ({1'b0, row} < nb_rows);
        flags.act   = in_cols && in_rows;
    end

endmodule

// File: rtl/vtg_timing_gen.sv
module vtg_timing_gen
    import vtg_pkg::*;
#(
    parameter int COL_W = 12,
    parameter int ROW_W = 12
) (
    input  logic             clk,
    input  logic             ce,
    input  logic             sclr,
    input  logic             vblank_in,
    input  logic [1:0]       polarity,
    input  logic [COL_W-1:0] total_cols,
    input  logic [ROW_W-1:0] total_rows,
    input  logic [ROW_W-1:0] blank_rows,
    input  logic [COL_W-1:0] blank_left,
    input  logic [COL_W-1:0] blank_right,
    input  logic [COL_W-1:0] active_left,
    input  logic [COL_W-1:0] active_right,
    input  logic [ROW_W-1:0] active_top,
    input  logic [ROW_W-1:0] active_bottom,
    output logic             hblank_out,
    output logic             vblank_out,
    output logic             active_out
);

    logic [COL_W-1:0] col_q;
    logic [ROW_W-1:0] row_q;
    vtg_flags_t       flags;
    vtg_out_t         out_d, out_q;
    logic [1:0]       vis;
    logic [1:0]       sense;

    vtg_counter #(.COL_W(COL_W), .ROW_W(ROW_W)) u_cnt (
        .clk        (clk),
        .ce         (ce),
        .sclr       (sclr),
        .vblank_in  (vblank_in),
        .total_cols (total_cols),
        .total_rows (total_rows),
        .col        (col_q),
        .row        (row_q)
    );

    vtg_window #(.COL_W(COL_W), .ROW_W(ROW_W)) u_win (
        .col           (col_q),
        .row           (row_q),
        .total_rows    (total_rows),
        .blank_rows    (blank_rows),
        .blank_left    (blank_left),
        .blank_right   (blank_right),
        .active_left   (active_left),
        .active_right  (active_right),
        .active_top    (active_top),
        .active_bottom (active_bottom),
        .flags         (flags)
    );

    // Apply per-signal sense: bit POL_H horizontal, bit POL_V vertical.
    always_comb begin
        vis[POL_H] = flags.h_vis;
        vis[POL_V] = flags.v_vis;
        for (int i = 0; i < 2; i++) begin
            sense[i] = polarity[i] ? vis[i] : ~vis[i];
        end
        out_d = out_q;
        if (ce) begin
            out_d.hb = sense[POL_H];
            out_d.vb = sense[POL_V];
            out_d.av = flags.act;
        end
    end

    always_ff @(posedge clk) begin
        if (sclr) out_q <= '0;
        else      out_q <= out_d;
    end

    assign hblank_out = out_q.hb;
    assign vblank_out = out_q.vb;
    assign active_out = out_q.av;

endmodule

// File: rtl/vtg_checker.sv
module vtg_checker #(
    parameter int COL_W = 12
) (
    input logic             clk,
    input logic             ce,
    input logic             sclr,
    input logic             vblank_in,
    input logic [1:0]       polarity,
    input logic [COL_W-1:0] total_cols,
    input logic [COL_W-1:0] col_q,
    input logic             hblank_out,
    input logic             vblank_out,
    input logic             active_out
);

    AST_CLEAR_ZERO: assert property (@(posedge clk)
        sclr |=> (!hblank_out && !vblank_out && !active_out)); // R1

    AST_COL_RANGE: assert property (@(posedge clk) disable iff (sclr)
        col_q < total_cols); // R2

    AST_ACT_IN_WINDOW: assert property (@(posedge clk) disable iff (sclr)
        active_out |-> (hblank_out == polarity[0] && vblank_out == polarity[1])); // R5

    AST_RESYNC_ORIGIN: assert property (@(posedge clk) disable iff (sclr)
        ($past(ce, 3) && $past(vblank_in, 3) && $past(ce, 2) && !$past(vblank_in, 2)
         && $past(ce) && !$past(sclr) && !$past(sclr, 2) && !$past(sclr, 3))
        |-> (vblank_out == polarity[1] && !active_out)); // R6

    AST_CE_HOLD: assert property (@(posedge clk) disable iff (sclr)
        !ce |=> ($stable(hblank_out) && $stable(vblank_out) && $stable(active_out))); // R8

endmodule

bind vtg_timing_gen vtg_checker #(.COL_W(COL_W)) u_chk (
    .clk        (clk),
    .ce         (ce),
    .sclr       (sclr),
    .vblank_in  (vblank_in),
    .polarity   (polarity),
    .total_cols (total_cols),
    .col_q      (col_q),
    .hblank_out (hblank_out),
    .vblank_out (vblank_out),
    .active_out (active_out)
);

// File: tb/vtg_timing_gen_bench.sv
module vtg_timing_gen_bench;

    localparam int CLK_PERIOD = 10;
    localparam int COL_W = 12;
    localparam int ROW_W = 12;

    logic clk = 1'b0;
    logic ce = 1'b0;
    logic sclr = 1'b1;
    logic vblank_in = 1'b0;
    logic [1:0] polarity = 2'b00;
    logic [COL_W-1:0] total_cols = 48, blank_left = 2, blank_right = 42;
    logic [COL_W-1:0] active_left = 6, active_right = 40;
    logic [ROW_W-1:0] total_rows = 44, blank_rows = 4, active_top = 2, active_bottom = 36;
    logic hblank_out, vblank_out, active_out;

    int errors = 0;
    int checks = 0;
    string phase = "R1";

    // reference model state
    int  m_col = 0, m_row = 0;
    bit  m_prev = 0;
    bit  e_hb = 0, e_vb = 0, e_av = 0;

    // input stream generator
    int in_cnt = 0, in_period = 2112, in_blank = 192;

    always #(CLK_PERIOD / 2) clk = ~clk;

    vtg_timing_gen #(.COL_W(COL_W), .ROW_W(ROW_W)) u_vtg_timing_gen (
        .clk (clk), .ce (ce), .sclr (sclr), .vblank_in (vblank_in),
        .polarity (polarity), .total_cols (total_cols), .total_rows (total_rows),
        .blank_rows (blank_rows), .blank_left (blank_left), .blank_right (blank_right),
        .active_left (active_left), .active_right (active_right),
        .active_top (active_top), .active_bottom (active_bottom),
        .hblank_out (hblank_out), .vblank_out (vblank_out), .active_out (active_out)
    );

    // Behavioural reference: raster position, then registered decode.
    always @(posedge clk) begin
        bit hv, vv, av;
        if (sclr) begin
            m_col = 0; m_row = 0; m_prev = 0;
            e_hb = 0; e_vb = 0; e_av = 0;
        end else if (ce) begin
            hv = (m_col >= int'(blank_left)) && (m_col < int'(blank_right));
            vv = m_row < (int'(total_rows) - int'(blank_rows));
            av = (m_col >= int'(active_left)) && (m_col < int'(active_right))
                 && (m_row >= int'(active_top)) && (m_row < int'(active_bottom));
            e_hb = polarity[0] ? hv : !hv;
            e_vb = polarity[1] ? vv : !vv;
            e_av = av;
            if (m_prev && !vblank_in) begin
                m_col = 0; m_row = 0;
            end else begin
                m_col++;
                if (m_col >= int'(total_cols)) begin
                    m_col = 0;
                    m_row++;
                    if (m_row >= int'(total_rows)) m_row = 0;
                end
            end
            m_prev = vblank_in;
        end
    end

    task automatic chk(input string req, input bit act, input bit exp, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s (%s) %s: actual=%0b expected=%0b at %0t", req, phase, what, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        chk("R3", hblank_out, e_hb, "hblank_out");
        chk("R4", vblank_out, e_vb, "vblank_out");
        chk("R5", active_out, e_av, "active_out");
    endtask

    // ce_mode: 0 = always on, 1 = gated pattern
    task automatic run(input int n, input int ce_mode);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            compare_all();
            in_cnt++;
            vblank_in = (in_cnt % in_period) < in_blank;
            ce = (ce_mode == 0) ? 1'b1 : ((i % 7) != 3 && (i % 11) != 5);
        end
    endtask

    task automatic do_clear(input int n);
        sclr = 1'b1;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (i > 0) begin
                chk("R1", hblank_out, 1'b0, "hblank_out during clear");
                chk("R1", vblank_out, 1'b0, "vblank_out during clear");
                chk("R1", active_out, 1'b0, "active_out during clear");
            end
        end
        sclr = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int  last_rise;
        int  rise_cnt;
        bit  prev_h;
        bit  hold_h, hold_v, hold_a;

        // R1: reset state
        phase = "R1 clear";
        ce = 1'b1;
        do_clear(4);

        // Config A, blank signalling on both (polarity 00), frame-aligned input; R2 R7
        phase = "R2 raster, R7 pol=00";
        in_cnt = 0; in_period = 2112; in_blank = 192;
        run(6500, 0);

        // R2: horizontal period measured at the port
        last_rise = -1; rise_cnt = 0; prev_h = hblank_out;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            compare_all();
            if (hblank_out && !prev_h) begin
                if (last_rise >= 0 && rise_cnt == 1)
                    chk("R2", (i - last_rise) == int'(total_cols), 1'b1, "hblank period == total_cols");
                last_rise = i;
                rise_cnt++;
            end
            prev_h = hblank_out;
            in_cnt++;
            vblank_in = (in_cnt % in_period) < in_blank;
        end

        // Config B: valid signalling (11), input frame not a raster multiple -> mid-line resync; R6 R7
        do_clear(3);
        polarity = 2'b11;
        total_cols = 50; blank_left = 4; blank_right = 44; active_left = 8; active_right = 42;
        total_rows = 40; blank_rows = 3; active_top = 1; active_bottom = 34;
        phase = "R6 resync, R7 pol=11";
        in_cnt = 0; in_period = 2023; in_blank = 150;
        run(7000, 0);

        // R8: gated enable with resync still running
        phase = "R8 ce gating";
        run(6000, 1);
        // explicit hold check over a long ce-low stretch
        @(negedge clk);
        compare_all();
        ce = 1'b0;
        @(negedge clk);
        compare_all();
        hold_h = hblank_out; hold_v = vblank_out; hold_a = active_out;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            compare_all();
            in_cnt++;
            vblank_in = (in_cnt % in_period) < in_blank;
            chk("R8", hblank_out, hold_h, "hblank_out held with ce low");
            chk("R8", vblank_out, hold_v, "vblank_out held with ce low");
            chk("R8", active_out, hold_a, "active_out held with ce low");
        end

        // Config C: mixed polarity (01), clear mid-frame then resync; R1 R7
        do_clear(2);
        polarity = 2'b01;
        total_cols = 48; blank_left = 4; blank_right = 42; active_left = 4; active_right = 42;
        total_rows = 44; blank_rows = 4; active_top = 0; active_bottom = 38;
        phase = "R7 pol=01";
        in_cnt = 700; in_period = 2112; in_blank = 192;
        run(3000, 0);
        phase = "R1 mid-run clear";
        do_clear(3);
        phase = "R6 resync after clear";
        run(4500, 1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule